// File: doc/BRIEF.md
# Multi-Pass Window Convolution Engine

This block forms a two-dimensional weighted sum of an image neighbourhood. Every pixel strobe brings one new column of eight vertically aligned pixels: the current line and seven delayed lines, which the line stores outside this block provide. The block shifts that column into an 8x8 window register. A 16-lane multiplier-accumulator array then sweeps the active part of the window against 64 signed 8-bit weights held in an internal register file.

The array covers one 4x4 tile per clock. Larger windows and 16-bit pixels therefore need two or four clocks per pixel, and the pixel rate drops to one half or one quarter of the clock rate. The total is kept in a 32-bit accumulator. A signed partial sum from an upstream unit is added to it, so several units can be chained to cover larger windows. A left-shift gain then moves the significant bits to the top of the 32-bit word, and the result saturates instead of wrapping. A bypass setting passes the window's centre pixel through the same pipeline unchanged.

Top module: `conv_mac_array`

## Requirements
- R1: While reset is low and on the first cycle after it is released, `res_vld` is 0 and `res_out` is 0. All weights reset to 0.
- R2: A weight write with `coef_we`=1 stores `coef_wdata` (signed 8-bit) at the position row=`coef_addr[5:3]`, column=`coef_addr[2:0]`. Pixels strobed after the write use the new value.
- R3: `win_mode` selects the window. 0 gives 4 columns x 4 rows, 1 gives 8 columns x 4 rows, and 2 or 3 gives 8 columns x 8 rows. Weights and pixels outside the window have no effect.
- R4: The number of passes P is 1, 2 or 4: 4x4 with 8-bit pixels takes 1, 8x4 or 16-bit 4x4 takes 2, and 8x8 or 16-bit 8x4 takes 4. `res_vld` goes high P+1 clocks after the clock edge that samples `pix_stb`. Strobes may repeat every P clocks.
- R5: With `wide_pix`=1 each pixel is the full unsigned 16-bit tap, and `win_mode` 2 or 3 acts as 8x4.
- R6: With `wide_pix`=0 only bits [7:0] of each tap count, as an unsigned value. Bits [15:8] are ignored.
- R7: The signed `casc_in` is added to the window sum before the gain.
- R8: The sum is shifted left by `gain_sh` (0 to 31) and saturated to the range 0x80000000 to 0x7FFFFFFF.
- R9: With `bypass`=1 the output is the pixel at row 1, column 1, zero-extended (only bits [7:0] when `wide_pix`=0). The latency is the same, and neither the gain nor `casc_in` applies.
- R10: Row r of the window takes `taps[16r+15:16r]`. Column c holds the tap that arrived c strobes earlier, and column 0 is the newest.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | MAC clock |
| rst_n | input | 1 | asynchronous reset, active low |
| coef_we | input | 1 | weight write enable |
| coef_addr | input | 6 | weight address: row in [5:3], column in [2:0] |
| coef_wdata | input | 8 | signed weight |
| win_mode | input | 2 | window size select |
| wide_pix | input | 1 | 16-bit pixel mode |
| bypass | input | 1 | forward the centre pixel |
| pix_stb | input | 1 | new pixel column present on taps |
| taps | input | 128 | eight 16-bit pixels, row 0 in bits [15:0] |
| casc_in | input | 32 | signed partial sum from an upstream unit |
| gain_sh | input | 5 | output left-shift amount |
| res_out | output | 32 | result |
| res_vld | output | 1 | result valid |

## Verification
Random weights and random 16-bit taps are run in every window and pixel-width mode at the fastest strobe spacing. The taps carry live upper bytes even in 8-bit mode, so a lane that wrongly reads those bits shows up. Weight sets with a single nonzero entry in a far column or row test the address decoding and the window shift on their own. Large all-ones pixels with extreme weights and large gains reach both saturation limits, while random cascade values with zero gain show the adder without shifting. Bypass runs with nonzero gain and cascade check that the filter path is fully cut off.

// File: rtl/conv_mac_array.sv
module conv_mac_array #(
  parameter int PIX_W = 16,
  parameter int NROW  = 8
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  coef_we,
  input  logic [5:0]            coef_addr,
  input  logic [7:0]            coef_wdata,
  input  logic [1:0]            win_mode,
  input  logic                  wide_pix,
  input  logic                  bypass,
  input  logic                  pix_stb,
  input  logic [NROW*PIX_W-1:0] taps,
  input  logic [31:0]           casc_in,
  input  logic [4:0]            gain_sh,
  output logic [31:0]           res_out,
  output logic                  res_vld
);
  localparam int NCOL = 8;
  localparam int NCOEF = NROW * NCOL;

  logic signed [7:0] coef [NCOEF];
  logic [PIX_W-1:0]  win [NROW][NCOL];
  logic [1:0]        pc;
  logic              run, done;
  logic signed [31:0] acc, part;
  logic [15:0]       cpix;

  wire       cols8  = |win_mode;
  wire       rows8  = win_mode[1] & ~wide_pix;
  wire [1:0] pc_last = {wide_pix ? cols8 : rows8, wide_pix | cols8};
  wire       bsel   = wide_pix & pc[0];
  wire [1:0] rest   = wide_pix ? {1'b0, pc[1]} : pc;
  wire       chalf  = cols8 & rest[0];
  wire       rhalf  = rows8 & rest[1];

  always_comb begin
    logic [2:0] rr, cc;
    logic [7:0] px;
    part = '0;
    for (int i = 0; i < 4; i++) begin
      for (int j = 0; j < 4; j++) begin
        rr = {rhalf, 2'(i)};
        cc = {chalf, 2'(j)};
        px = bsel ? win[rr][cc][15:8] : win[rr][cc][7:0];
        part = part + 32'(coef[{rr, cc}]) * 32'($signed({1'b0, px}));
      end
    end
    if (bsel) part = part <<< 8;
  end

  wire signed [63:0] wsum = 64'(acc) + 64'($signed(casc_in));
  wire signed [63:0] shv  = wsum <<< gain_sh;
  wire [31:0] satv = (shv > 64'sd2147483647)  ? 32'h7fff_ffff :
                     (shv < -64'sd2147483648) ? 32'h8000_0000 : shv[31:0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int k = 0; k < NCOEF; k++) coef[k] <= '0;
      for (int r = 0; r < NROW; r++)
        for (int c = 0; c < NCOL; c++) win[r][c] <= '0;
      pc <= '0;
      run <= 1'b0;
      done <= 1'b0;
      acc <= '0;
      cpix <= '0;
      res_out <= '0;
      res_vld <= 1'b0;
    end else begin
      if (coef_we) coef[coef_addr] <= coef_wdata;
      if (pix_stb) begin
        for (int r = 0; r < NROW; r++) begin
          win[r][0] <= taps[r*PIX_W +: PIX_W];
          for (int c = 1; c < NCOL; c++) win[r][c] <= win[r][c-1];
        end
      end
      if (run) acc <= (pc == 2'd0) ? part : acc + part;
      done <= run && (pc == pc_last);
      if (run && pc == pc_last)
        cpix <= wide_pix ? win[1][1] : {8'h00, win[1][1][7:0]};
      if (pix_stb) begin
        pc <= '0;
        run <= 1'b1;
      end else if (run) begin
        if (pc == pc_last) run <= 1'b0;
        else pc <= pc + 2'd1;
      end
      res_vld <= done;
      if (done) res_out <= bypass ? {16'h0000, cpix} : satv;
    end
  end
endmodule

// File: rtl/conv_mac_chk.sv
module conv_mac_chk (
  input logic              clk,
  input logic              rst_n,
  input logic              coef_we,
  input logic [5:0]        coef_addr,
  input logic [7:0]        coef_wdata,
  input logic signed [7:0] coef [64],
  input logic              run,
  input logic [1:0]        pc,
  input logic [1:0]        pc_last,
  input logic              done,
  input logic              bypass,
  input logic              res_vld,
  input logic [31:0]       res_out
);
  // R2
  coef_wr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    coef_we |=> coef[$past(coef_addr)] == $past(coef_wdata));
  // R4
  pass_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    run |-> pc <= pc_last);
  // R4
  done_to_vld_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> res_vld);
  // R4
  vld_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    res_vld |-> $past(done));
  // R9
  bypass_ext_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (res_vld && $past(bypass)) |-> res_out[31:16] == 16'h0000);
endmodule

bind conv_mac_array conv_mac_chk u_chk (
  .clk(clk), .rst_n(rst_n), .coef_we(coef_we), .coef_addr(coef_addr),
  .coef_wdata(coef_wdata), .coef(coef), .run(run), .pc(pc), .pc_last(pc_last),
  .done(done), .bypass(bypass), .res_vld(res_vld), .res_out(res_out)
);

// File: tb/test_conv_mac_array.sv
module test_conv_mac_array;
  localparam int CLK_T = 10;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic coef_we = 1'b0;
  logic [5:0] coef_addr = '0;
  logic [7:0] coef_wdata = '0;
  logic [1:0] win_mode = '0;
  logic wide_pix = 1'b0;
  logic bypass = 1'b0;
  logic pix_stb = 1'b0;
  logic [127:0] taps = '0;
  logic [31:0] casc_in = '0;
  logic [4:0] gain_sh = '0;
  logic [31:0] res_out;
  logic res_vld;

  conv_mac_array i_conv_mac_array (
    .clk(clk), .rst_n(rst_n), .coef_we(coef_we), .coef_addr(coef_addr),
    .coef_wdata(coef_wdata), .win_mode(win_mode), .wide_pix(wide_pix),
    .bypass(bypass), .pix_stb(pix_stb), .taps(taps), .casc_in(casc_in),
    .gain_sh(gain_sh), .res_out(res_out), .res_vld(res_vld)
  );

  always #(CLK_T/2) clk = ~clk;

  int checks = 0;
  int errs = 0;
  string cur_req = "R1";
  int cm [64];
  int wm [8][8];
  int dq [$];
  logic [31:0] vq [$];

  function automatic int npass();
    int h, w;
    h = (win_mode[1] && !wide_pix) ? 2 : 1;
    w = (win_mode != 2'd0) ? 2 : 1;
    return (wide_pix ? 2 : 1) * h * w;
  endfunction

  function automatic logic [31:0] model_out();
    longint s;
    longint px;
    int h, w;
    if (bypass) return wide_pix ? 32'(wm[1][1]) : 32'(wm[1][1] & 255);
    h = (win_mode[1] && !wide_pix) ? 8 : 4;
    w = (win_mode != 2'd0) ? 8 : 4;
    s = 0;
    for (int r = 0; r < h; r++)
      for (int c = 0; c < w; c++) begin
        px = wide_pix ? longint'(wm[r][c]) : longint'(wm[r][c] & 255);
        s = s + longint'(cm[r*8+c]) * px;
      end
    s = s + longint'($signed(casc_in));
    s = s <<< gain_sh;
    if (s > 64'sd2147483647) return 32'h7fff_ffff;
    if (s < -64'sd2147483648) return 32'h8000_0000;
    return s[31:0];
  endfunction

  function automatic logic [127:0] rnd();
    return {$urandom, $urandom, $urandom, $urandom};
  endfunction

  task automatic check_out();
    bit ev;
    ev = (dq.size() > 0) && (dq[0] == 0);
    checks++;
    if (res_vld !== ev) begin
      errs++;
      $display("FAIL R4: res_vld=%b expected %b (%s)", res_vld, ev, cur_req);
    end
    if (ev) begin
      checks++;
      if (res_out !== vq[0]) begin
        errs++;
        $display("FAIL %s: res_out=%h expected %h", cur_req, res_out, vq[0]);
      end
    end
  endtask

  task automatic cyc(input bit s, input logic [127:0] t);
    @(negedge clk);
    check_out();
    pix_stb = s;
    taps = t;
    @(posedge clk);
    #1;
    if (dq.size() > 0 && dq[0] == 0) begin
      void'(dq.pop_front());
      void'(vq.pop_front());
    end
    foreach (dq[k]) dq[k] = dq[k] - 1;
    if (s) begin
      for (int r = 0; r < 8; r++) begin
        for (int c = 7; c > 0; c--) wm[r][c] = wm[r][c-1];
        wm[r][0] = int'(t[r*16 +: 16]);
      end
      dq.push_back(npass() + 1);
      vq.push_back(model_out());
    end
  endtask

  task automatic run_px(input int n, input bit ones);
    for (int i = 0; i < n; i++) begin
      cyc(1'b1, ones ? '1 : rnd());
      for (int k = 1; k < npass(); k++) cyc(1'b0, rnd());
    end
  endtask

  task automatic drain();
    for (int i = 0; i < 7; i++) cyc(1'b0, rnd());
  endtask

  task automatic wcoef(input int a, input int v);
    @(negedge clk);
    coef_we = 1'b1;
    coef_addr = 6'(a);
    coef_wdata = 8'(v);
    @(posedge clk);
    #1;
    cm[a] = v;
    coef_we = 1'b0;
  endtask

  task automatic fill_coef(input int kind);
    for (int a = 0; a < 64; a++)
      case (kind)
        0: wcoef(a, 0);
        1: wcoef(a, int'($urandom_range(0, 255)) - 128);
        2: wcoef(a, 127);
        default: wcoef(a, -128);
      endcase
  endtask

  task automatic set_cfg(input logic [1:0] m, input bit w);
    win_mode = m;
    wide_pix = w;
  endtask

  initial begin
    #(CLK_T * 200000);
    errs++;
    $display("FAIL R4: watchdog expired, got no end, expected end of run");
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end

  initial begin
    for (int a = 0; a < 64; a++) cm[a] = 0;
    for (int r = 0; r < 8; r++) for (int c = 0; c < 8; c++) wm[r][c] = 0;

    repeat (3) @(posedge clk);
    @(negedge clk);
    checks++;
    if (res_vld !== 1'b0 || res_out !== 32'h0) begin
      errs++;
      $display("FAIL R1: vld=%b out=%h expected 0 0 in reset", res_vld, res_out);
    end
    rst_n = 1'b1;
    @(negedge clk);
    checks++;
    if (res_vld !== 1'b0 || res_out !== 32'h0) begin
      errs++;
      $display("FAIL R1: vld=%b out=%h expected 0 0 after reset", res_vld, res_out);
    end
    cur_req = "R1";
    set_cfg(2'd2, 1'b0);
    run_px(3, 1'b0);
    drain();

    cur_req = "R2";
    fill_coef(0);
    wcoef(2*8+5, -77);
    set_cfg(2'd1, 1'b0);
    run_px(12, 1'b0);
    drain();

    cur_req = "R10";
    wcoef(2*8+5, 0);
    wcoef(0*8+7, 53);
    run_px(14, 1'b0);
    drain();
    wcoef(0*8+7, 0);
    wcoef(7*8+3, -9);
    set_cfg(2'd2, 1'b0);
    run_px(10, 1'b0);
    drain();

    fill_coef(1);
    for (int m = 0; m < 4; m++) begin
      cur_req = "R3";
      set_cfg(2'(m), 1'b0);
      run_px(20, 1'b0);
      drain();
    end
    cur_req = "R6";
    set_cfg(2'd0, 1'b0);
    run_px(20, 1'b0);
    drain();

    for (int m = 0; m < 3; m++) begin
      cur_req = "R5";
      set_cfg(2'(m), 1'b1);
      run_px(20, 1'b0);
      drain();
    end

    cur_req = "R7";
    for (int k = 0; k < 4; k++) begin
      casc_in = $urandom;
      set_cfg(2'(k % 3), k[0]);
      run_px(10, 1'b0);
      drain();
    end
    casc_in = 32'h7fff_0000;
    set_cfg(2'd2, 1'b0);
    run_px(5, 1'b0);
    drain();

    cur_req = "R8";
    casc_in = '0;
    for (int g = 0; g < 4; g++) begin
      gain_sh = 5'((g == 3) ? 31 : g * 5 + 3);
      set_cfg(2'd1, 1'b1);
      fill_coef(2);
      run_px(4, 1'b1);
      drain();
      fill_coef(3);
      run_px(4, 1'b1);
      drain();
      fill_coef(1);
      run_px(6, 1'b0);
      drain();
    end

    cur_req = "R9";
    bypass = 1'b1;
    gain_sh = 5'd7;
    casc_in = 32'h1234_5678;
    for (int m = 0; m < 3; m++) begin
      set_cfg(2'(m), 1'b0);
      run_px(8, 1'b0);
      drain();
      set_cfg(2'(m), 1'b1);
      run_px(8, 1'b0);
      drain();
    end
    bypass = 1'b0;
    gain_sh = '0;
    casc_in = '0;

    cur_req = "R4";
    set_cfg(2'd0, 1'b0);
    run_px(30, 1'b0);
    for (int i = 0; i < 10; i++) begin
      cyc(1'b1, rnd());
      cyc(1'b0, rnd());
      cyc(1'b0, rnd());
    end
    drain();

    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end
endmodule